// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Controller

This block sits between a synchronous requester and an asynchronous page-mode DRAM. Each request carries a write flag, a cell address and write data. The controller splits the address into a row part and a column part. It drives both parts, one after the other, over a single narrow address bus, and generates the row strobe, column strobe and write strobe with the timing that the memory needs. Every strobe is active low. Read data returns on a one-cycle valid pulse.

The controller remembers which row is currently open. If a request falls in that row, the row stays active and only a column strobe pulse is issued, which gives a short page cycle. If a request falls in another row, the row strobe is first held high for the precharge interval and the new row is then opened. After reset, after a refresh, and after the open row has been closed for inactivity, no row is open, so the next access always runs the full row cycle. A refresh engine asks for the memory through a request/grant pair. The grant is given only once the open row has been closed.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, dram_ras_n, dram_cas_n and dram_we_n are high, req_ready is high, and rd_valid and ref_gnt are low.
- R2: When no row is open, an accepted request drives dram_ras_n low with the row part on dram_addr, without a preceding precharge.
- R3: The upper ADDR_W bits of req_addr are the row, driven on dram_addr while dram_ras_n falls. The lower ADDR_W bits are the column, driven on dram_addr while dram_cas_n falls.
- R4: A read captures dram_dq_i at the end of the column strobe pulse and presents it on rd_data with rd_valid high for exactly one cycle.
- R5: During the column strobe of a write, dram_we_n is low, dram_dq_oe is high and dram_dq_o equals the request data. dram_we_n is never low while dram_cas_n is high.
- R6: A request to the open row produces a column strobe pulse with no edge on dram_ras_n.
- R7: A request to a row other than the open row raises dram_ras_n for exactly T_RP cycles before it falls again for the new row.
- R8: dram_ras_n stays low for at least T_RAS cycles before it rises.
- R9: dram_cas_n is low only while dram_ras_n is low. In a full row cycle, dram_cas_n falls exactly T_RCD cycles after dram_ras_n falls.
- R10: After IDLE_LIM cycles without a request, the open row is closed (dram_ras_n goes high). The next access then runs a full row cycle.
- R11: While ref_req is high, no request is accepted. ref_gnt is asserted only with dram_ras_n and dram_cas_n both high, and the first access after the refresh runs a full row cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ADDR_W | Cell address, row in upper half, column in lower half |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read data pulse |
| rd_data | output | DATA_W | Read data |
| ref_req | input | 1 | Refresh engine asks for the memory |
| ref_gnt | output | 1 | Memory idle and handed to refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_dq_o | output | DATA_W | Write data to memory |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_i | input | DATA_W | Read data from memory |

## Verification
The bench builds the controller with a 6-bit multiplexed bus and 8-bit data. It sets T_RAS to 7, which is longer than the 5 cycles a freshly opened access takes. An immediate change of row must therefore wait for the minimum row-active time, and the bench measures that wait from the strobe edges. IDLE_LIM is set to 8, so the inactivity close happens within a short wait. With T_RP at 3 and T_RCD at 2, the precharge width and the row-to-column delay are exact cycle counts that the bench compares against the parameters.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_CP     = 1,
  parameter int T_RP     = 3,
  parameter int T_RAS    = 6,
  parameter int IDLE_LIM = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [2*ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  ref_req,
  output logic                  ref_gnt,
  output logic                  dram_ras_n,
  output logic                  dram_cas_n,
  output logic                  dram_we_n,
  output logic [ADDR_W-1:0]     dram_addr,
  output logic [DATA_W-1:0]     dram_dq_o,
  output logic                  dram_dq_oe,
  input  logic [DATA_W-1:0]     dram_dq_i
);

  localparam int TA   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TB   = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int TMAX = (TA > TB) ? TA : TB;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RSW  = $clog2(T_RAS + 1);
  localparam int IW   = $clog2(IDLE_LIM + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_CAS, S_CP, S_REF} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [RSW-1:0]    ras_cnt;
  logic [IW-1:0]     idle_cnt;
  logic              row_open, pend, we_q;
  logic [ADDR_W-1:0] row_q, col_q, open_row;
  logic [DATA_W-1:0] wd_q;

  wire [ADDR_W-1:0] req_row = req_addr[2*ADDR_W-1:ADDR_W];
  wire hit      = row_open && (req_row == open_row);
  wire ras_ok   = ras_cnt >= RSW'(T_RAS - 1);
  wire idle_exp = idle_cnt >= IW'(IDLE_LIM - 1);
  wire accept   = req_valid && req_ready;

  assign req_ready  = (st == S_IDLE) && !ref_req && (!row_open || hit || ras_ok);
  assign ref_gnt    = (st == S_REF);
  assign dram_ras_n = !row_open;
  assign dram_cas_n = (st != S_CAS);
  assign dram_we_n  = !((st == S_CAS) && we_q);
  assign dram_dq_oe = (st == S_CAS) && we_q;
  assign dram_dq_o  = wd_q;
  assign dram_addr  = (st == S_CAS) ? col_q : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ras_cnt  <= '0;
      idle_cnt <= '0;
      row_open <= 1'b0;
      pend     <= 1'b0;
      we_q     <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      open_row <= '0;
      wd_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (row_open && ras_cnt != RSW'(T_RAS)) ras_cnt <= ras_cnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (!row_open) idle_cnt <= '0;
          else if (idle_cnt != IW'(IDLE_LIM)) idle_cnt <= idle_cnt + 1'b1;
          if (accept) begin
            we_q     <= req_we;
            wd_q     <= req_wdata;
            row_q    <= req_row;
            col_q    <= req_addr[ADDR_W-1:0];
            idle_cnt <= '0;
            if (hit) begin
              st  <= S_CAS;
              cnt <= CW'(T_CAS - 1);
            end else if (row_open) begin
              st       <= S_PRE;
              cnt      <= CW'(T_RP - 1);
              row_open <= 1'b0;
              pend     <= 1'b1;
            end else begin
              st       <= S_ACT;
              cnt      <= CW'(T_RCD - 1);
              row_open <= 1'b1;
              open_row <= req_row;
              ras_cnt  <= '0;
            end
          end else if (row_open && ras_ok && (ref_req || idle_exp)) begin
            st       <= S_PRE;
            cnt      <= CW'(T_RP - 1);
            row_open <= 1'b0;
            pend     <= 1'b0;
            idle_cnt <= '0;
          end else if (!row_open && ref_req) begin
            st <= S_REF;
          end
        end
        S_PRE: if (cnt == '0) begin
          if (pend) begin
            st       <= S_ACT;
            cnt      <= CW'(T_RCD - 1);
            row_open <= 1'b1;
            open_row <= row_q;
            ras_cnt  <= '0;
            pend     <= 1'b0;
          end else begin
            st <= S_IDLE;
          end
        end
        S_ACT: if (cnt == '0) begin
          st  <= S_CAS;
          cnt <= CW'(T_CAS - 1);
        end
        S_CAS: if (cnt == '0) begin
          if (!we_q) begin
            rd_data  <= dram_dq_i;
            rd_valid <= 1'b1;
          end
          st  <= S_CP;
          cnt <= CW'(T_CP - 1);
        end
        S_CP: if (cnt == '0) st <= S_IDLE;
        S_REF: if (!ref_req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RCD = 2,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic rd_valid,
  input logic ref_gnt,
  input logic req_ready
);

  localparam int LMAX = (T_RAS > T_RCD) ? T_RAS : T_RCD;
  localparam int LW   = $clog2(LMAX + 1);
  localparam int PW   = $clog2(T_RP + 1);

  logic [LW-1:0] lo_cnt;
  logic [PW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= PW'(T_RP);
    end else begin
      if (ras_n) lo_cnt <= '0;
      else if (lo_cnt != LW'(LMAX)) lo_cnt <= lo_cnt + 1'b1;
      if (!ras_n) hi_cnt <= '0;
      else if (hi_cnt != PW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> hi_cnt >= PW'(T_RP)); // R7
  AST_RAS_ACTIVE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> lo_cnt >= LW'(T_RAS)); // R8
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R9
  AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n) $fell(cas_n) |-> lo_cnt >= LW'(T_RCD)); // R9
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !cas_n); // R5
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R4
  AST_REF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ref_gnt |-> (ras_n && cas_n && !req_ready)); // R11

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .rd_valid(rd_valid), .ref_gnt(ref_gnt), .req_ready(req_ready)
);

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int AW = 6, DW = 8;
  localparam int P_RCD = 2, P_CAS = 2, P_CP = 1, P_RP = 3, P_RAS = 7, P_IDLE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, dram_dq_i = '0;
  logic req_ready, rd_valid, ref_gnt, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DW-1:0] rd_data, dram_dq_o;
  logic [AW-1:0] dram_addr;

  always #4 clk = ~clk;

  fpm_dram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP),
                  .T_RP(P_RP), .T_RAS(P_RAS), .IDLE_LIM(P_IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_addr(dram_addr), .dram_dq_o(dram_dq_o),
    .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i));

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // strobe monitor, sampled on the falling clock edge
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int ras_falls = 0, ras_rises = 0, cas_falls = 0;
  int lo = 0, hi = 0, rcd_seen = 0, pre_seen = 0, low_seen = 0;
  int row_seen = 0, col_seen = 0, we_seen = 0, oe_seen = 0, dq_seen = 0;

  always @(negedge clk) begin
    if (prev_ras && !dram_ras_n) begin
      ras_falls++; row_seen = int'(dram_addr); pre_seen = hi + 1; lo = 0;
    end else if (!dram_ras_n) lo++;
    if (!prev_ras && dram_ras_n) begin
      ras_rises++; low_seen = lo + 1; hi = 0;
    end else if (dram_ras_n) hi++;
    if (prev_cas && !dram_cas_n) begin
      cas_falls++; col_seen = int'(dram_addr); rcd_seen = lo;
      we_seen = int'(!dram_we_n); oe_seen = int'(dram_dq_oe); dq_seen = int'(dram_dq_o);
    end
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int got_rd;
  task automatic access(input bit we, input int row, input int col, input int data);
    int snap_c;
    snap_c = cas_falls;
    @(negedge clk);
    req_valid = 1'b1; req_we = we;
    req_addr = {AW'(row), AW'(col)};
    req_wdata = DW'(data);
    dram_dq_i = we ? '0 : DW'(data);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (cas_falls == snap_c) @(negedge clk);
    if (!we) begin
      while (!rd_valid) @(negedge clk);
      got_rd = int'(rd_data);
      @(negedge clk);
      chk("R4 rd_valid width", int'(rd_valid), 0);
    end
  endtask

  // {we, row, col, data, kind}; kind 0 = no row open, 1 = same row, 2 = other row
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 6'd5, 6'd3,  8'hA1, 2'd0},
    {1'b1, 6'd5, 6'd7,  8'h3C, 2'd1},
    {1'b0, 6'd5, 6'd0,  8'h55, 2'd1},
    {1'b0, 6'd9, 6'd1,  8'h7E, 2'd2},
    {1'b1, 6'd9, 6'd63, 8'hC3, 2'd1},
    {1'b1, 6'd2, 6'd2,  8'h11, 2'd2},
    {1'b0, 6'd3, 6'd2,  8'h99, 2'd2},
    {1'b0, 6'd3, 6'd40, 8'h5A, 2'd1}
  };

  initial begin
    int f0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ras_n", int'(dram_ras_n), 1);
    chk("R1 cas_n", int'(dram_cas_n), 1);
    chk("R1 we_n", int'(dram_we_n), 1);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 ref_gnt", int'(ref_gnt), 0);

    for (int i = 0; i < 8; i++) begin
      bit we; int row, col, data, kind;
      we = VEC[i][22]; row = int'(VEC[i][21:16]); col = int'(VEC[i][15:10]);
      data = int'(VEC[i][9:2]); kind = int'(VEC[i][1:0]);
      f0 = ras_falls; r0 = ras_rises;
      access(we, row, col, data);
      chk(kind == 1 ? "R6 ras falls" : "R2 ras falls", ras_falls - f0, kind == 1 ? 0 : 1);
      chk(kind == 2 ? "R7 ras rises" : "R6 ras rises", ras_rises - r0, kind == 2 ? 1 : 0);
      if (kind != 1) begin
        chk("R3 row addr", row_seen, row);
        chk("R9 ras to cas", rcd_seen, P_RCD);
      end
      if (kind == 2) begin
        chk("R7 precharge width", pre_seen, P_RP);
        chk("R8 ras active min", int'(low_seen >= P_RAS), 1);
      end
      chk("R3 col addr", col_seen, col);
      if (we) begin
        chk("R5 we strobe", we_seen, 1);
        chk("R5 dq enable", oe_seen, 1);
        chk("R5 dq data", dq_seen, data);
      end else begin
        chk("R5 read we strobe", we_seen, 0);
        chk("R4 read data", got_rd, data);
      end
    end

    // R10: inactivity close
    r0 = ras_rises;
    repeat (2) @(negedge clk);
    chk("R10 row still open", int'(dram_ras_n), 0);
    repeat (P_IDLE + P_RP + P_RAS) @(negedge clk);
    chk("R10 row closed", int'(dram_ras_n), 1);
    chk("R10 one precharge", ras_rises - r0, 1);
    f0 = ras_falls; r0 = ras_rises;
    access(1'b0, 3, 1, 8'h42);
    chk("R10 full cycle after close", ras_falls - f0, 1);
    chk("R10 no extra precharge", ras_rises - r0, 0);
    chk("R10 read data", got_rd, 8'h42);

    // R11: refresh handover
    @(negedge clk);
    ref_req = 1'b1;
    while (!ref_gnt) @(negedge clk);
    chk("R11 ras high at grant", int'(dram_ras_n), 1);
    chk("R11 cas high at grant", int'(dram_cas_n), 1);
    chk("R11 no accept", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk("R11 grant held", int'(ref_gnt), 1);
    ref_req = 1'b0;
    @(negedge clk);
    chk("R11 grant released", int'(ref_gnt), 0);
    f0 = ras_falls;
    access(1'b0, 3, 5, 8'hE7);
    chk("R11 full cycle after refresh", ras_falls - f0, 1);
    chk("R11 row after refresh", row_seen, 3);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R1-watch actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule